// File: doc/BRIEF.md
# SD Host Command Issue Engine

This block is the command half of an SD/MMC host controller. Software loads a 32-bit argument and then writes a 16-bit command word. Writing the upper byte of that word launches a 48-bit command frame on the serial CMD line. The frame is sent most significant bit first, one bit per clock. The block then waits for the card's reply and stores it. The 2-bit response-type code in the command word selects the reply handling: no reply, a 136-bit reply, a 48-bit reply, or a 48-bit reply followed by a busy phase on DAT0.

Two separate inhibit flags tell software when a new command may be issued. The CMD flag covers the command line and the DAT flag covers the data lines. The block checks the reply for CRC, index and end-bit errors and for a missing start bit. Each of these outcomes is latched as a write-one-to-clear status bit. A masked summary bit combines the error bits. The clock is the card clock: the block shifts and samples one CMD bit on each rising edge.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset the CMD line is released (`cmd_oe`=0) and idles high, both inhibit flags are 0, all status bits are 0 and the stored response is 0.
- R2: A write to the command word with `cmd_be[1]` set while CMD inhibit is 0 starts a command. For the 48 clocks that follow, the block drives `cmd_oe` high and places on `cmd_out`, most significant bit first, the frame {0, 1, index = command bits 13:8, argument, CRC7 (polynomial x^7+x^3+1, taken over the first 40 bits), 1}. CMD inhibit (present-state bit 0) is held for the whole command.
- R3: A command-word write while CMD inhibit is set is ignored: the frame in flight is unchanged and no further frame follows.
- R4: The response type sits in command bits 1:0 (00 none, 01 136-bit, 10 48-bit, 11 48-bit then busy). With type 00, command complete (status bit 0) is set and CMD inhibit clears on the edge that ends the frame.
- R5: For a 48-bit reply, the 32 bits between the index field and the CRC field are stored in `resp[31:0]`. Command complete is set one clock after the end bit is sampled.
- R6: For a 136-bit reply, the 120 bits between the 8-bit header and the CRC field are stored right-aligned in `resp[119:0]`, and `resp[127:120]` is 0.
- R7: If no start bit (0) is sampled within RESP_TIMEOUT clocks after the last command bit, the timeout bit (status bit 16) and command complete are set and CMD inhibit clears.
- R8: With the CRC-check enable (command bit 3) set, a reply CRC7 mismatch sets status bit 17. With the enable clear, a mismatch is not reported.
- R9: With the index-check enable (command bit 4) set, a 48-bit reply whose index differs from the command sets status bit 19. No index check is made on a 136-bit reply. A 0 end bit sets status bit 18.
- R10: Status bit 15 is the OR of the error bits 16..19, each gated by the matching bit 0..3 of `err_en`.
- R11: A status write clears exactly the latched bits written as 1 and leaves the others set.
- R12: DAT inhibit (present-state bit 1) is set when a command carries data-present (command bit 5) or has type 11. For type 11 it stays set after command complete until DAT0 is sampled high, and that edge also sets status bit 1. For data-present commands a `data_done` pulse clears it.
- R13: Present-state bits 23:20 show the live level of `dat_in[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; one CMD bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_be | input | 2 | Byte enables of the command word; bit 1 launches |
| cmd_wdata | input | 16 | Command word value |
| sts_wr | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 32 | Bits to clear |
| err_en | input | 4 | Enables of the error bits into the summary bit |
| data_done | input | 1 | End-of-transfer pulse from the data path |
| cmd_in | input | 1 | Sampled CMD line level |
| cmd_out | output | 1 | Driven CMD level |
| cmd_oe | output | 1 | CMD line output enable |
| dat_in | input | 4 | Live DAT[3:0] levels |
| present_state | output | 32 | Inhibit flags and DAT levels |
| int_status | output | 32 | Latched completion and error bits |
| resp | output | 128 | Stored response |

## Verification
The bench builds the engine with RESP_TIMEOUT set to 16. This brings the timeout edge within a short run. The bench places one reply start bit on the last clock that is still accepted, and lets another command run past the window with no start bit at all. Each command is followed clock by clock against a behavioural model of the line, which checks every frame bit and the exact edge where CMD inhibit drops. Injected CRC, index and end-bit faults check each error bit and the masked summary. A full 136-bit reply checks the right-aligned storage.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int RESP_TIMEOUT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arg_wr,
  input  logic [31:0]  arg_wdata,
  input  logic         cmd_wr,
  input  logic [1:0]   cmd_be,
  input  logic [15:0]  cmd_wdata,
  input  logic         sts_wr,
  input  logic [31:0]  sts_wdata,
  input  logic [3:0]   err_en,
  input  logic         data_done,
  input  logic         cmd_in,
  output logic         cmd_out,
  output logic         cmd_oe,
  input  logic [3:0]   dat_in,
  output logic [31:0]  present_state,
  output logic [31:0]  int_status,
  output logic [127:0] resp
);

  localparam int TW = (RESP_TIMEOUT > 1) ? $clog2(RESP_TIMEOUT) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(RESP_TIMEOUT - 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_CHK} state_t;

  state_t         st;
  logic [7:0]     cnt;
  logic [TW-1:0]  wcnt;
  logic [47:0]    tx_sr;
  logic [135:0]   rx_sr;
  logic [31:0]    arg_q;
  logic [5:0]     idx_q;
  logic [7:0]     lo_q;
  logic           inh_cmd, inh_dat, busy_wait, cc, xc;
  logic [3:0]     err;

  function automatic logic [6:0] crc7(input logic [135:0] d, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 135; i >= 0; i--) begin
      if (i < n) begin
        fb = d[i] ^ c[6];
        c = {c[5:0], 1'b0};
        if (fb) c = c ^ 7'h09;
      end
    end
    return c;
  endfunction

  wire [7:0]  lo_new  = cmd_be[0] ? cmd_wdata[7:0] : lo_q;
  wire        issue   = cmd_wr && cmd_be[1] && !inh_cmd;
  wire [39:0] head    = {2'b01, cmd_wdata[13:8], arg_q};
  wire [6:0]  tx_crc  = crc7({96'b0, head}, 40);
  wire [1:0]  rt      = lo_q[1:0];
  wire        is_long = (rt == 2'b01);
  wire [7:0]  rx_last = is_long ? 8'd135 : 8'd47;
  wire [6:0]  rx_crc  = is_long ? crc7({16'b0, rx_sr[127:8]}, 120)
                                : crc7({96'b0, rx_sr[47:8]}, 40);
  wire        crc_bad = lo_q[3] && (rx_crc != rx_sr[7:1]);
  wire        idx_bad = lo_q[4] && !is_long && (rx_sr[45:40] != idx_q);
  wire        end_bad = !rx_sr[0];

  logic unused_bits;
  assign unused_bits = ^{cmd_wdata[15:14], sts_wdata[31:20], sts_wdata[15:2],
                         rx_sr[135:128], lo_q[7:6], lo_q[2]};

  assign cmd_oe        = (st == S_TX);
  assign cmd_out       = cmd_oe ? tx_sr[47] : 1'b1;
  assign present_state = {8'b0, dat_in, 18'b0, inh_dat, inh_cmd};
  assign int_status    = {12'b0, err, |(err & err_en), 13'b0, xc, cc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wcnt <= '0; tx_sr <= '1; rx_sr <= '0;
      arg_q <= '0; idx_q <= '0; lo_q <= '0; resp <= '0;
      inh_cmd <= 1'b0; inh_dat <= 1'b0; busy_wait <= 1'b0;
      cc <= 1'b0; xc <= 1'b0; err <= '0;
    end else begin
      if (arg_wr) arg_q <= arg_wdata;
      if (sts_wr) begin
        cc  <= cc & ~sts_wdata[0];
        xc  <= xc & ~sts_wdata[1];
        err <= err & ~sts_wdata[19:16];
      end
      if (busy_wait && dat_in[0]) begin
        busy_wait <= 1'b0;
        xc <= 1'b1;
        if (!lo_q[5]) inh_dat <= 1'b0;
      end
      if (data_done && !busy_wait) inh_dat <= 1'b0;

      case (st)
        S_TX: begin
          tx_sr <= {tx_sr[46:0], 1'b1};
          cnt   <= cnt + 8'd1;
          if (cnt == 8'd47) begin
            wcnt <= '0;
            if (rt == 2'b00) begin
              cc <= 1'b1; inh_cmd <= 1'b0; st <= S_IDLE;
            end else begin
              st <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (!cmd_in) begin
            rx_sr <= {rx_sr[134:0], cmd_in};
            cnt   <= 8'd1;
            st    <= S_RX;
          end else if (wcnt == T_LAST) begin
            err[0] <= 1'b1; cc <= 1'b1; inh_cmd <= 1'b0;
            if (!lo_q[5]) inh_dat <= 1'b0;
            st <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_RX: begin
          rx_sr <= {rx_sr[134:0], cmd_in};
          cnt   <= cnt + 8'd1;
          if (cnt == rx_last) st <= S_CHK;
        end
        S_CHK: begin
          cc <= 1'b1;
          inh_cmd <= 1'b0;
          if (crc_bad) err[1] <= 1'b1;
          if (end_bad) err[2] <= 1'b1;
          if (idx_bad) err[3] <= 1'b1;
          if (is_long) resp <= {8'b0, rx_sr[127:8]};
          else         resp[31:0] <= rx_sr[39:8];
          if (rt == 2'b11) busy_wait <= 1'b1;
          st <= S_IDLE;
        end
        default: ;
      endcase

      if (issue) begin
        idx_q   <= cmd_wdata[13:8];
        lo_q    <= lo_new;
        tx_sr   <= {head, tx_crc, 1'b1};
        cnt     <= '0;
        inh_cmd <= 1'b1;
        st      <= S_TX;
        if (lo_new[5] || lo_new[1:0] == 2'b11) inh_dat <= 1'b1;
      end else if (cmd_wr && cmd_be[0] && !inh_cmd) begin
        lo_q <= cmd_wdata[7:0];
      end
    end
  end

  AST_OE_HOLDS_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> present_state[0]); // R2
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (cnt <= 8'd47)); // R2
  AST_START_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> $past(cmd_wr && cmd_be[1] && !present_state[0])); // R3
  AST_CHECK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK) |=> int_status[0]); // R5
  AST_TIMEOUT_FREES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[16]) |-> !present_state[0]); // R7
  AST_BUSY_HOLDS_DAT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_wait |-> present_state[1]); // R12

endmodule

// File: tb/sd_cmd_engine_test.sv
module sd_cmd_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arg_wr = 1'b0;
  logic [31:0] arg_wdata = '0;
  logic cmd_wr = 1'b0;
  logic [1:0] cmd_be = '0;
  logic [15:0] cmd_wdata = '0;
  logic sts_wr = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic [3:0] err_en = 4'hF;
  logic data_done = 1'b0;
  logic cmd_in = 1'b1;
  logic [3:0] dat_in = 4'hF;
  logic cmd_out, cmd_oe;
  logic [31:0] present_state, int_status;
  logic [127:0] resp;

  sd_cmd_engine #(.RESP_TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
    .cmd_wr(cmd_wr), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .err_en(err_en),
    .data_done(data_done), .cmd_in(cmd_in), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .dat_in(dat_in), .present_state(present_state),
    .int_status(int_status), .resp(resp));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check_eq(input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [135:0] d, input int n);
    logic [6:0] r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic top = r[6];
      r = r << 1;
      if (top != d[i]) r = r ^ 7'b0001001;
    end
    return r;
  endfunction

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] p,
                                             input bit bad_crc, input bit bad_end);
    logic [39:0] h = {2'b00, idx, p};
    logic [6:0] c = ref_crc({96'b0, h}, 40) ^ (bad_crc ? 7'h01 : 7'h00);
    return {88'b0, h, c, ~bad_end};
  endfunction

  task automatic clear_sts(input logic [31:0] bits);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = bits;
    @(negedge clk); sts_wr = 1'b0;
  endtask

  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                      input logic dp, input logic ichk, input logic cchk, input int d,
                      input logic [135:0] rf, input int rlen, input bit poke);
    logic [47:0] fr;
    int end_m;
    @(negedge clk); arg_wr = 1'b1; arg_wdata = arg;
    @(negedge clk); arg_wr = 1'b0;
    fr = {2'b01, idx, arg, ref_crc({96'b0, 2'b01, idx, arg}, 40), 1'b1};
    end_m = (rt == 2'b00) ? 48 : (d < 0) ? 48 + TO : 49 + d + rlen;
    cmd_wr = 1'b1; cmd_be = 2'b11;
    cmd_wdata = {2'b00, idx, 2'b00, dp, ichk, cchk, 1'b0, rt};
    for (int m = 0; m < end_m + 3; m++) begin
      int k;
      @(negedge clk);
      cmd_wr = 1'b0;
      if (poke && m == 5) begin
        cmd_wr = 1'b1; cmd_be = 2'b11; cmd_wdata = {2'b00, 6'd9, 8'h02};
      end
      check_eq(m < 48 ? "R2 line enable" : "R3 R4 line idle after frame", cmd_oe, m < 48);
      if (m < 48) check_eq("R2 R3 frame bit", cmd_out, fr[47 - m]);
      check_eq("R4 R5 R7 cmd inhibit timing", present_state[0], m < end_m);
      k = m - 48 - d;
      cmd_in = (rt != 2'b00 && d >= 0 && k >= 0 && k < rlen) ? rf[rlen - 1 - k] : 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [119:0] pl;
    repeat (3) @(negedge clk);
    check_eq("R1 oe", cmd_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 oe", cmd_oe, 0);
    check_eq("R1 line high", cmd_out, 1);
    check_eq("R1 status", int_status, 0);
    check_eq("R1 inhibits", present_state[1:0], 0);
    check_eq("R1 resp", resp, 0);

    dat_in = 4'b1010;
    @(negedge clk);
    check_eq("R13 dat levels", present_state[23:20], 4'hA);
    dat_in = 4'hF;

    // type 00 with an ignored write during the frame
    send(6'd0, 32'h0, 2'b00, 0, 0, 0, 0, '0, 0, 1);
    check_eq("R4 complete", int_status, 32'h1);
    check_eq("R3 no second command", cmd_oe, 0);
    clear_sts(32'h1);
    check_eq("R11 clear", int_status, 0);

    // 48-bit reply
    send(6'd17, 32'h12345678, 2'b10, 0, 1, 1, 3, short_rsp(6'd17, 32'hCAFEF00D, 0, 0), 48, 0);
    check_eq("R5 status", int_status, 32'h1);
    check_eq("R5 payload", resp[31:0], 32'hCAFEF00D);
    clear_sts('1);

    // start bit on the last accepted clock
    send(6'd13, 32'hA5A50001, 2'b10, 0, 1, 1, TO - 1, short_rsp(6'd13, 32'h0BADBEEF, 0, 0), 48, 0);
    check_eq("R7 boundary no timeout", int_status, 32'h1);
    check_eq("R7 boundary payload", resp[31:0], 32'h0BADBEEF);
    clear_sts('1);

    // no reply at all
    send(6'd8, 32'h000001AA, 2'b10, 0, 1, 1, -1, '0, 48, 0);
    check_eq("R7 timeout status", int_status, 32'h00018001);
    clear_sts(32'h1);
    check_eq("R11 partial clear", int_status, 32'h00018000);
    err_en = 4'h0;
    @(negedge clk);
    check_eq("R10 masked summary", int_status, 32'h00010000);
    err_en = 4'hF;
    clear_sts('1);

    // CRC fault
    send(6'd17, 32'h1, 2'b10, 0, 0, 1, 2, short_rsp(6'd17, 32'h55AA55AA, 1, 0), 48, 0);
    check_eq("R8 crc error", int_status, 32'h00028001);
    clear_sts('1);
    send(6'd17, 32'h1, 2'b10, 0, 0, 0, 2, short_rsp(6'd17, 32'h55AA55AA, 1, 0), 48, 0);
    check_eq("R8 crc check off", int_status, 32'h1);
    clear_sts('1);

    // index fault with index error masked from summary
    err_en = 4'b0111;
    send(6'd17, 32'h2, 2'b10, 0, 1, 1, 1, short_rsp(6'd5, 32'h00000900, 0, 0), 48, 0);
    check_eq("R9 R10 index error masked", int_status, 32'h00080001);
    err_en = 4'hF;
    @(negedge clk);
    check_eq("R9 R10 index error summary", int_status, 32'h00088001);
    clear_sts('1);

    // end bit fault
    send(6'd7, 32'h3, 2'b10, 0, 1, 1, 0, short_rsp(6'd7, 32'h0000FFFF, 0, 1), 48, 0);
    check_eq("R9 end bit error", int_status, 32'h00048001);
    clear_sts('1);

    // 136-bit reply, index check requested but not applied
    pl = {32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C, 24'h4B5A69};
    send(6'd2, 32'h0, 2'b01, 0, 1, 1, 4,
         {2'b00, 6'h3F, pl, ref_crc({16'b0, pl}, 120), 1'b1}, 136, 0);
    check_eq("R6 R9 long status", int_status, 32'h1);
    check_eq("R6 long payload", resp, {8'h00, pl});
    clear_sts('1);

    // busy after reply
    dat_in = 4'b1110;
    send(6'd12, 32'h0, 2'b11, 0, 1, 1, 2, short_rsp(6'd12, 32'h00000B00, 0, 0), 48, 0);
    check_eq("R12 busy dat inhibit", present_state[1], 1);
    check_eq("R12 busy status", int_status, 32'h1);
    repeat (4) @(negedge clk);
    check_eq("R12 still busy", present_state[1], 1);
    dat_in = 4'hF;
    @(negedge clk);
    check_eq("R12 busy released", present_state[1], 0);
    check_eq("R12 busy end status", int_status, 32'h3);
    clear_sts('1);

    // data-present command
    send(6'd18, 32'h200, 2'b10, 1, 1, 1, 2, short_rsp(6'd18, 32'h00000900, 0, 0), 48, 0);
    check_eq("R12 data inhibit set", present_state[1], 1);
    check_eq("R12 data cmd status", int_status, 32'h1);
    data_done = 1'b1;
    @(negedge clk);
    data_done = 1'b0;
    check_eq("R12 data inhibit cleared", present_state[1], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule